// File: doc/BRIEF.md
# Dual-Source Scanline Interrupt Counter

This block is an 8-bit down-counter that raises a level interrupt request when it reaches zero. It has two clock sources, and a mode bit selects between them. In edge mode the counter advances on rising edges of the pattern-address line A12. Only a rise that follows a long enough low phase counts, as measured by a dot-cycle count supplied with each A12 sample. In cycle mode a divide-by-four prescaler advances the counter on every fourth CPU cycle.

Software controls the block through four write-only targets: the reload value, the mode/reload trigger, interrupt disable and interrupt enable. A reload that is armed by a mode write adds one or two to the reload value before the decrement, depending on that value. Leaving cycle mode lets one more prescaler wrap clock the counter. The interrupt line rises one CPU cycle after a prescaler-driven zero, or two CPU cycles after an edge-driven zero. It stays high until software disables the interrupt.

The block works in one clock domain. `cpu_ce` marks CPU cycles and `a12_valid` marks A12 samples. The two strobes are never high in the same clock cycle.

Top module: `dual_src_irq_counter`

## Requirements
- R1: After reset, `irq_o` is 0, the interrupt is disabled, the counter, prescaler and all flags are 0, and the block is in edge mode, so CPU cycles alone never clock the counter.
- R2: A write with `wr_sel`=0 stores `wr_data` as the reload value. A write with `wr_sel`=1 arms a pending reload and sets cycle mode from `wr_data[0]` (1 = cycle mode). A write that selects cycle mode also clears the prescaler.
- R3: In cycle mode the counter is clocked on every fourth `cpu_ce`, counted from the last prescaler clear.
- R4: A counter clock with a reload pending loads reload+1 if the reload value is 0 or 1, and reload+2 otherwise. It then decrements (modulo 256) and clears the pending flag.
- R5: A counter clock with no reload pending and the counter at 0 loads reload+1 and then decrements. In every other case the clock simply decrements the counter.
- R6: When a prescaler-driven clock leaves the counter at 0 with the interrupt enabled, `irq_o` rises at the next `cpu_ce`.
- R7: When an edge-driven clock leaves the counter at 0 with the interrupt enabled, `irq_o` rises at the second `cpu_ce` after the edge.
- R8: In edge mode the counter is clocked only by an A12 sample that is high, whose previous sample was low, and whose `dot_count` is at least 30 dots (modulo 2^16) past the sample where A12 fell. In cycle mode A12 edges do not clock the counter.
- R9: A write with `wr_sel`=1 and `wr_data[0]`=0 made while in cycle mode forces exactly one more counter clock. That clock comes at the next prescaler wrap. After it, CPU cycles no longer clock the counter.
- R10: A write with `wr_sel`=2 disables the interrupt, drops `irq_o` in the next cycle and cancels any pending assertion. A write with `wr_sel`=3 enables the interrupt. While the interrupt is disabled, `irq_o` never rises.
- R11: Once high, `irq_o` stays high until a write with `wr_sel`=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_ce | input | 1 | One-cycle strobe marking a CPU cycle |
| a12_valid | input | 1 | One-cycle strobe marking a valid A12 sample |
| a12_in | input | 1 | Sampled level of pattern-address line A12 |
| dot_count | input | 16 | Dot-cycle count belonging to the A12 sample |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 reload, 1 mode, 2 disable, 3 enable |
| wr_data | input | 8 | Write data |
| irq_o | output | 1 | Level interrupt request |

## Verification
Counter clocks are internal, so every result is checked by when `irq_o` changes. For a prescaler-driven zero, the line changes at the clock edge of the next `cpu_ce`. For an edge-driven zero, it changes at the edge of the second `cpu_ce` after the qualifying A12 sample. For a disable write, it falls at the edge that registers the write. The bench drives inputs at the falling edge, updates its reference state right after the rising edge from the same inputs, and samples `irq_o` at the next falling edge, so each expected value lands in the cycle it is due. The directed checks count whole CPU cycles, each one `cpu_ce` cycle followed by two idle cycles. They confirm low on the cycle before each expected rise and high on the cycle of the rise.

// File: rtl/irq_cnt_pkg.sv
// Package: shared write-target and clock-source encodings for the
// dual-source interrupt counter. Assumes a 2-bit write selector.
package irq_cnt_pkg;

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_OFF    = 2'd2,
        SEL_ON     = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CPU  = 2'd1,
        SRC_A12  = 2'd2
    } clk_src_e;

endpackage

// File: rtl/a12_edge_filter.sv
// Module: a12_edge_filter
// Detects qualified rising edges of A12. A rise counts only when the
// line has been low for at least MIN_LOW dots. The low phase is measured
// from the dot count of the sample where the line fell.
// Assumes dot_cnt is a free-running count that wraps modulo 2^DOT_W and
// that the low phase is shorter than 2^DOT_W dots.
module a12_edge_filter #(
    parameter int DOT_W   = 16,
    parameter int MIN_LOW = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_vld,
    input  logic             a12_lvl,
    input  logic [DOT_W-1:0] dot_cnt,
    output logic             rise_ok
);

    localparam logic [DOT_W-1:0] MinLowC = DOT_W'(MIN_LOW);

    logic             prev_q;
    logic [DOT_W-1:0] low_start_q;
    logic [DOT_W-1:0] low_span;

    assign low_span = dot_cnt - low_start_q;
    assign rise_ok  = sample_vld && a12_lvl && !prev_q && (low_span >= MinLowC);

    // Track the previous level and the dot where the line last went low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= 1'b0;
            low_start_q <= '0;
        end else if (sample_vld) begin
            prev_q <= a12_lvl;
            if (!a12_lvl && prev_q) begin
                low_start_q <= dot_cnt;
            end
        end
    end

    // R8: a qualified rise leaves the line registered high.
    a_r8_high_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ok |=> prev_q);

    // R8: two qualified rises never come in consecutive cycles.
    a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rise_ok |=> !rise_ok);

endmodule

// File: rtl/cycle_prescaler.sv
// Module: cycle_prescaler
// Divides CPU cycles by 2^PRESC_W. It runs while cycle mode is on or a
// forced clock is pending, and pulses tick at each wrap to zero.
// Assumes the mode-write strobe and its bit come from the register port,
// and that cycle_mode is the registered mode before that write.
module cycle_prescaler #(
    parameter int PRESC_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ce,
    input  logic cycle_mode,
    input  logic mode_wr,
    input  logic mode_bit,
    output logic tick
);

    localparam logic [PRESC_W-1:0] WrapAt = '1;

    logic [PRESC_W-1:0] presc_q;
    logic               force_q;
    logic               run;

    assign run  = cpu_ce && (cycle_mode || force_q);
    assign tick = run && (presc_q == WrapAt);

    // Advance the prescaler and handle the forced clock on leaving cycle mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            force_q <= 1'b0;
        end else begin
            if (run) begin
                presc_q <= presc_q + 1'b1;
            end
            if (tick) begin
                force_q <= 1'b0;
            end
            if (mode_wr) begin
                if (mode_bit) begin
                    presc_q <= '0;
                end
                if (cycle_mode && !mode_bit) begin
                    force_q <= 1'b1;
                end
            end
        end
    end

    // R2: entering cycle mode restarts the division.
    a_r2_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_bit) |=> (presc_q == '0));

    // R9: leaving cycle mode arms the forced clock.
    a_r9_force_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && cycle_mode && !mode_bit) |=> force_q);

    // R9: the forced clock is spent by the wrap that delivers it.
    a_r9_force_once: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mode_wr) |=> !force_q);

endmodule

// File: rtl/irq_count_core.sv
// Module: irq_count_core
// Holds the control state, the down-counter and the delayed interrupt line.
// A counter clock comes from the prescaler tick, or from a qualified A12
// rise while in edge mode. A zero result arms a delay. The delay length
// depends on the source and counts down on CPU cycles.
// Assumes cpu_tick and a12_rise never arrive in the same cycle, and
// CPU_DLY, A12_DLY >= 1.
module irq_count_core
    import irq_cnt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int CPU_DLY = 1,
    parameter int A12_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_ce,
    input  logic             cpu_tick,
    input  logic             a12_rise,
    input  logic             wr_en,
    input  wr_sel_e          wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             cycle_mode,
    output logic             irq
);

    localparam int MaxDly = (CPU_DLY > A12_DLY) ? CPU_DLY : A12_DLY;
    localparam int DLY_W  = $clog2(MaxDly + 1);

    logic             mode_q;
    logic             en_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic [DLY_W-1:0] dly_q;
    logic             irq_q;
    clk_src_e         src;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wr_mode;
    logic             wr_off;

    // Result of one counter clock: reload arithmetic folded with the decrement.
    function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] rl,
                                                 input logic             pend);
        if (pend) begin
            return (rl <= CNT_W'(1)) ? rl : rl + 1'b1;
        end else if (cur == '0) begin
            return rl;
        end
        return cur - 1'b1;
    endfunction

    assign wr_mode = wr_en && (wr_sel == SEL_MODE);
    assign wr_off  = wr_en && (wr_sel == SEL_OFF);

    // Pick the source of this cycle's counter clock, if any.
    always_comb begin
        if (cpu_tick) begin
            src = SRC_CPU;
        end else if (a12_rise && !mode_q) begin
            src = SRC_A12;
        end else begin
            src = SRC_NONE;
        end
    end

    assign cnt_nxt = advance(cnt_q, reload_q, pend_q);

    // Register writes to mode, enable and reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            en_q     <= 1'b0;
            reload_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_RELOAD: reload_q <= wr_data;
                SEL_MODE:   mode_q   <= wr_data[0];
                SEL_OFF:    en_q     <= 1'b0;
                SEL_ON:     en_q     <= 1'b1;
                default:    en_q     <= en_q;
            endcase
        end
    end

    // Counter update on each clock; a mode write re-arms the reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (src != SRC_NONE) begin
                cnt_q  <= cnt_nxt;
                pend_q <= 1'b0;
            end
            if (wr_mode) begin
                pend_q <= 1'b1;
            end
        end
    end

    // Assertion delay and interrupt line; a disable write wins over all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (cpu_ce && (dly_q != '0)) begin
                dly_q <= dly_q - 1'b1;
                if (dly_q == DLY_W'(1)) begin
                    irq_q <= 1'b1;
                end
            end
            if ((src != SRC_NONE) && (cnt_nxt == '0) && en_q) begin
                dly_q <= (src == SRC_CPU) ? DLY_W'(CPU_DLY) : DLY_W'(A12_DLY);
            end
            if (wr_off) begin
                dly_q <= '0;
                irq_q <= 1'b0;
            end
        end
    end

    assign cycle_mode = mode_q;
    assign irq        = irq_q;

    // R6: the line only rises on a CPU cycle.
    a_r6_rise_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(cpu_ce));

    // R10: a disable write drops the line in the next cycle.
    a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_off |=> !irq_q);

    // R10: the line never rises while the interrupt is disabled.
    a_r10_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(en_q));

    // R11: the line holds until a disable write.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !wr_off) |=> irq_q);

    // R8: an A12 rise in cycle mode leaves the counter untouched.
    a_r8_a12_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && a12_rise && !cpu_tick) |=> $stable(cnt_q));

    // R4: a counter clock consumes the pending reload.
    a_r4_pend_used: assert property (@(posedge clk) disable iff (!rst_n)
        ((src != SRC_NONE) && !wr_mode) |=> !pend_q);

endmodule

// File: rtl/dual_src_irq_counter.sv
// Module: dual_src_irq_counter (top)
// Interrupt counter clocked by filtered A12 rises or by a divided CPU
// cycle strobe. Write targets: 0 reload value, 1 mode/reload trigger,
// 2 disable, 3 enable.
// Assumes cpu_ce and a12_valid are never high in the same cycle.
module dual_src_irq_counter
    import irq_cnt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DOT_W   = 16,
    parameter int MIN_LOW = 30,
    parameter int PRESC_W = 2,
    parameter int CPU_DLY = 1,
    parameter int A12_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_ce,
    input  logic             a12_valid,
    input  logic             a12_in,
    input  logic [DOT_W-1:0] dot_count,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             irq_o
);

    wr_sel_e sel;
    logic    a12_rise;
    logic    cpu_tick;
    logic    cycle_mode;
    logic    mode_wr;

    assign sel     = wr_sel_e'(wr_sel);
    assign mode_wr = wr_en && (sel == SEL_MODE);

    a12_edge_filter #(
        .DOT_W   (DOT_W),
        .MIN_LOW (MIN_LOW)
    ) u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (a12_valid),
        .a12_lvl    (a12_in),
        .dot_cnt    (dot_count),
        .rise_ok    (a12_rise)
    );

    cycle_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_ce     (cpu_ce),
        .cycle_mode (cycle_mode),
        .mode_wr    (mode_wr),
        .mode_bit   (wr_data[0]),
        .tick       (cpu_tick)
    );

    irq_count_core #(
        .CNT_W   (CNT_W),
        .CPU_DLY (CPU_DLY),
        .A12_DLY (A12_DLY)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_ce     (cpu_ce),
        .cpu_tick   (cpu_tick),
        .a12_rise   (a12_rise),
        .wr_en      (wr_en),
        .wr_sel     (sel),
        .wr_data    (wr_data),
        .cycle_mode (cycle_mode),
        .irq        (irq_o)
    );

endmodule

// File: tb/tb_dual_src_irq_counter.sv
// Bench for dual_src_irq_counter: directed corner cases plus seeded random
// traffic, compared cycle by cycle against a reference state kept in tasks.
module tb_dual_src_irq_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_ce = 1'b0;
    logic        a12_valid = 1'b0;
    logic        a12_in = 1'b0;
    logic [15:0] dot_count = 16'd0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic lvl = 1'b0;

    // reference state
    logic        m_mode, m_en, m_pend, m_force, m_irq, m_prev;
    logic [7:0]  m_rl, m_cnt;
    logic [1:0]  m_presc;
    int          m_dly;
    logic [15:0] m_low;

    dual_src_irq_counter dut (
        .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .a12_valid(a12_valid),
        .a12_in(a12_in), .dot_count(dot_count), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic model_reset();
        m_mode = 0; m_en = 0; m_pend = 0; m_force = 0; m_irq = 0; m_prev = 0;
        m_rl = 0; m_cnt = 0; m_presc = 0; m_dly = 0; m_low = 0;
    endtask

    // Reference update for one clock, from the requirements.
    task automatic model_step();
        logic run, tk, aclk;
        int   v;
        run  = cpu_ce && (m_mode || m_force);
        tk   = run && (m_presc == 2'd3);
        aclk = a12_valid && a12_in && !m_prev && (16'(dot_count - m_low) >= 16'd30) && !m_mode;
        if (cpu_ce && m_dly > 0) begin
            m_dly = m_dly - 1;
            if (m_dly == 0) m_irq = 1;
        end
        if (tk || aclk) begin
            if (m_pend) v = int'(m_rl) + ((m_rl <= 8'd1) ? 1 : 2);
            else if (m_cnt == 0) v = int'(m_rl) + 1;
            else v = int'(m_cnt);
            m_cnt  = 8'((v - 1) & 255);
            m_pend = 0;
            if (m_cnt == 0 && m_en) m_dly = tk ? 1 : 2;
        end
        if (run) m_presc = m_presc + 2'd1;
        if (tk) m_force = 0;
        if (a12_valid) begin
            if (!a12_in && m_prev) m_low = dot_count;
            m_prev = a12_in;
        end
        if (wr_en) begin
            case (wr_sel)
                2'd0: m_rl = wr_data;
                2'd1: begin
                    if (m_mode && !wr_data[0]) m_force = 1;
                    if (wr_data[0]) m_presc = 0;
                    m_mode = wr_data[0];
                    m_pend = 1;
                end
                2'd2: begin m_en = 0; m_irq = 0; m_dly = 0; end
                default: m_en = 1;
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: irq_o actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, update reference, compare.
    task automatic step(input logic ce, input logic av, input logic a,
                        input logic we, input logic [1:0] sel, input logic [7:0] d);
        cpu_ce = ce; a12_valid = av; a12_in = a; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R6 R7 R11 trace", irq_o, m_irq);
        if (av) dot_count = dot_count + 16'd1;
    endtask

    task automatic cpu(input int n);
        for (int i = 0; i < n; i++) begin
            step(1'b1, 1'b0, lvl, 1'b0, 2'd0, 8'd0);
            step(1'b0, 1'b0, lvl, 1'b0, 2'd0, 8'd0);
            step(1'b0, 1'b0, lvl, 1'b0, 2'd0, 8'd0);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        step(1'b0, 1'b0, lvl, 1'b1, sel, d);
    endtask

    task automatic a12s(input logic a);
        lvl = a;
        step(1'b0, 1'b1, a, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) a12s(1'b0);
        a12s(1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cpu_ce = 0; a12_valid = 0; wr_en = 0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        chk("R1 reset", irq_o, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] s;
        logic [7:0] d;
        void'($urandom(32'h5EED_1234));
        model_reset();
        @(negedge clk);
        do_reset();

        // R1: edge mode after reset, CPU cycles alone do nothing
        wr(2'd3, 8'd0);
        cpu(8);
        chk("R1 no clock in edge mode", irq_o, 1'b0);

        // R8, R5, R7: short low phase ignored, long one clocks from zero
        a12s(1'b1);
        pulse(10);
        cpu(3);
        chk("R8 short low ignored", irq_o, 1'b0);
        pulse(30);
        chk("R7 not yet after edge", irq_o, 1'b0);
        cpu(1);
        chk("R7 first cpu cycle low", irq_o, 1'b0);
        cpu(1);
        chk("R7 second cpu cycle high", irq_o, 1'b1);
        cpu(5);
        chk("R11 held", irq_o, 1'b1);
        wr(2'd2, 8'd0);
        chk("R10 disable drops", irq_o, 1'b0);

        // R2, R3, R4, R6: reload 3 in cycle mode -> zero at 5th tick
        wr(2'd3, 8'd0);
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd1);
        cpu(20);
        chk("R4 reload3 low before", irq_o, 1'b0);
        cpu(1);
        chk("R6 reload3 high", irq_o, 1'b1);
        wr(2'd2, 8'd0);

        // R2, R4: reload 1 adds only one; prescaler restarted by mode write
        wr(2'd3, 8'd0);
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd1);
        cpu(8);
        chk("R2 R4 reload1 low before", irq_o, 1'b0);
        cpu(1);
        chk("R4 reload1 high", irq_o, 1'b1);
        wr(2'd2, 8'd0);

        // R9: leaving cycle mode with prescaler at 1 -> forced clock at 3rd cycle
        wr(2'd3, 8'd0);
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        cpu(3);
        chk("R9 forced low before", irq_o, 1'b0);
        cpu(1);
        chk("R9 forced clock high", irq_o, 1'b1);
        wr(2'd2, 8'd0);
        wr(2'd3, 8'd0);
        wr(2'd1, 8'd0);
        cpu(12);
        chk("R9 only one forced clock", irq_o, 1'b0);

        // R10: disable cancels a pending assertion; R6 after re-enable
        wr(2'd1, 8'd1);
        cpu(4);
        chk("R6 delay pending", irq_o, 1'b0);
        wr(2'd2, 8'd0);
        cpu(1);
        chk("R10 pending cancelled", irq_o, 1'b0);
        wr(2'd3, 8'd0);
        cpu(3);
        chk("R10 re-enabled low before", irq_o, 1'b0);
        cpu(1);
        chk("R6 re-enabled high", irq_o, 1'b1);
        wr(2'd2, 8'd0);

        // random traffic, R3 R4 R5 R8 R9 through the trace compare
        for (int k = 0; k < 9000; k++) begin
            if (k % 3 == 0) begin
                if ($urandom % 30 == 0) begin
                    s = 2'($urandom % 4);
                    if (s == 2'd2 && ($urandom % 2 == 0)) s = 2'd3;
                    d = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 5);
                    step(1'b1, 1'b0, lvl, 1'b1, s, d);
                end else begin
                    step(1'b1, 1'b0, lvl, 1'b0, 2'd0, 8'd0);
                end
            end else if ($urandom % 10 < 7) begin
                if ($urandom % 22 == 0) lvl = ~lvl;
                a12s(lvl);
            end else if ($urandom % 25 == 0) begin
                s = 2'($urandom % 4);
                if (s == 2'd2 && ($urandom % 2 == 0)) s = 2'd3;
                d = 8'($urandom % 6);
                wr(s, d);
            end else begin
                step(1'b0, 1'b0, lvl, 1'b0, 2'd0, 8'd0);
            end
        end

        // R1: reset mid-run returns to edge mode with line low
        do_reset();
        wr(2'd3, 8'd0);
        cpu(10);
        chk("R1 edge mode after second reset", irq_o, 1'b0);

        summary();
        $finish;
    end

endmodule